// File: doc/BRIEF.md
# Direct-Mapped Cache with Block Refill

This block sits between a processor load/store port and a slower, word-wide memory port. It keeps a small set of lines, each holding a valid flag, a tag and a block of several 32-bit words. A processor request carries a byte address, and exactly one line is consulted for it. When that line is valid and its tag matches the upper address bits, the addressed word is available combinationally in the same cycle. When either test fails, the block holds the processor in a stall, fetches the whole block from memory one word at a time, installs it, and then completes the access.

A parameter selects the store policy. In the write-through variant, every store sends its single word to memory and updates the line only if the line already holds that block. In the write-back variant, stores touch only the cache. Such a store sets a per-line dirty flag, and a dirty line is copied to memory as a whole block before a different block replaces it. A store that misses in write-back mode first fetches the block and then merges the store data into it.

The processor keeps `cpu_req_i`, `cpu_we_i`, `cpu_addr_i` and `cpu_wdata_i` steady while `cpu_stall_o` is high. An access completes in the cycle in which the request is high and the stall is low.

Top module: `dm_cache`

## Requirements
- R1: The address splits from the low end upward. Bits [1:0] are the byte position and have no effect. The next log2(LINE_WORDS) bits pick the word. The next log2(LINES) bits pick the line. The remaining upper bits form the tag.
- R2: A read hits when the indexed line is valid and its stored tag equals the address tag. On a hit the word appears on `cpu_rdata_o` in the same cycle, with no stall and no memory traffic.
- R3: On a miss, the whole block containing the requested word is read. The memory word address is {tag, index, word}, and the words are fetched in ascending order from 0 to LINE_WORDS-1. The valid flag is then set and the new tag is stored.
- R4: The stall is high in the request's first cycle and throughout the refill. It drops in the cycle after the last refill word is accepted.
- R5: Memory handshake: `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` stay steady until a cycle in which `mem_ready_i` is high. That cycle completes the transfer, and `mem_rdata_i` is taken in that same cycle.
- R6: Reset, active-low and asynchronous, clears every valid flag, so the first access to any address after reset misses. Out of reset there is no stall and no memory request.
- R7: With an 8-bit byte address (6-bit word address), 4 words per line and 4 lines, the word-address sequence 1,2,3,4,10,11,1,2,3,17,18,2,3,4 gives miss, hit, hit, miss, miss, hit, hit, hit, hit, miss, hit, miss, hit, hit.
- R8: Write-through: each store makes exactly one memory word write and stalls until that write is accepted. A store hit also updates the cached word. A store miss leaves the cache unchanged, so a later read of that address misses.
- R9: Write-through: replacing a line performs no memory write.
- R10: Write-back: a store hit completes without a stall. It updates only the cached word and marks the line dirty, and memory is not written.
- R11: Write-back: replacing a dirty line first writes all of its words to memory at the old tag's addresses in ascending order, then refills. Replacing a clean line performs no memory write.
- R12: Write-back: a store miss fetches the block and then merges the store word into it. The next read of that word hits and returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor access request |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Byte address |
| cpu_wdata_i | input | 32 | Store data |
| cpu_rdata_o | output | 32 | Load data, valid when the access completes |
| cpu_stall_o | output | 1 | Processor must hold its request |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = memory write |
| mem_addr_o | output | ADDR_W-2 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory accepts or completes the current transfer |

## Verification
The bench memory answers each word LAT+1 cycles after the request appears, with LAT = 3. This gives the following stall lengths:

- A hit completes in the cycle it is presented, with zero stalled cycles.
- A clean miss stalls for 1 + 4·(LAT+1) = 17 cycles.
- A dirty replacement stalls for 1 + 8·(LAT+1) = 33 cycles.
- A write-through store stalls for 1 + (LAT+1) = 5 cycles.

The bench drives each request at a falling edge and samples the stall one nanosecond later in every cycle, counting stalled cycles until the stall drops. It then compares that count and the returned word against the values above. Memory contents and write counts are read only after the access has completed, when every transfer it caused is already committed.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_WTSTORE,
    ST_RESUME
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 4,
  parameter int TAG_W = 2,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic             vld_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o,
  input  logic             inst_i,
  input  logic [TAG_W-1:0] inst_tag_i,
  input  logic             set_dirty_i
);
  logic [LINES-1:0] vld_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      dirty_q <= '0;
    end else if (inst_i) begin
      vld_q[idx_i]   <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (set_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (inst_i) tag_q[idx_i] <= inst_tag_i;
  end

  assign vld_o   = vld_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int LINES      = 4,
  parameter int LINE_WORDS = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFS_W = $clog2(LINE_WORDS)
) (
  input  logic             clk_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [OFS_W-1:0] rd_ofs_i,
  output logic [31:0]      rd_data_o,
  input  logic [OFS_W-1:0] ev_ofs_i,
  output logic [31:0]      ev_data_o,
  input  logic             we_i,
  input  logic [OFS_W-1:0] wr_ofs_i,
  input  logic [31:0]      wr_data_i
);
  logic [31:0] mem_q [LINES*LINE_WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[{idx_i, wr_ofs_i}] <= wr_data_i;
  end

  assign rd_data_o = mem_q[{idx_i, rd_ofs_i}];
  assign ev_data_o = mem_q[{idx_i, ev_ofs_i}];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter bit WRITE_BACK = 1'b1,
  localparam int OFS_W = $clog2(LINE_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             hit_i,
  input  logic             vld_i,
  input  logic             dirty_i,
  input  logic             mem_ready_i,
  output dmc_state_e       state_o,
  output logic [OFS_W-1:0] cnt_o,
  output logic             complete_o,
  output logic             stall_o,
  output logic             fill_we_o,
  output logic             inst_o,
  output logic             mem_req_o,
  output logic             mem_we_o
);
  dmc_state_e state_q, state_d;
  logic [OFS_W-1:0] cnt_q;
  logic last;

  assign last = (cnt_q == OFS_W'(LINE_WORDS - 1));

  always_comb begin
    complete_o = (state_q == ST_RESUME) ||
                 (state_q == ST_IDLE && req_i && hit_i && (!we_i || WRITE_BACK));
    stall_o    = req_i && !complete_o;
    mem_req_o  = (state_q == ST_EVICT) || (state_q == ST_FILL) || (state_q == ST_WTSTORE);
    mem_we_o   = (state_q == ST_EVICT) || (state_q == ST_WTSTORE);
    fill_we_o  = (state_q == ST_FILL) && mem_ready_i;
    inst_o     = fill_we_o && last;
    state_d    = state_q;
    unique case (state_q)
      ST_IDLE:
        if (stall_o) begin
          if (!WRITE_BACK && we_i)              state_d = ST_WTSTORE;
          else if (WRITE_BACK && vld_i && dirty_i) state_d = ST_EVICT;
          else                                  state_d = ST_FILL;
        end
      ST_EVICT:   if (mem_ready_i && last) state_d = ST_FILL;
      ST_FILL:    if (mem_ready_i && last) state_d = ST_RESUME;
      ST_WTSTORE: if (mem_ready_i)         state_d = ST_RESUME;
      ST_RESUME:                           state_d = ST_IDLE;
      default:                             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if ((state_q == ST_EVICT || state_q == ST_FILL) && mem_ready_i)
        cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 4,
  parameter bit WRITE_BACK = 1'b1,
  localparam int OFS_W   = $clog2(LINE_WORDS),
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_W   = ADDR_W - 2 - OFS_W - IDX_W,
  localparam int MADDR_W = ADDR_W - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_req_i,
  input  logic               cpu_we_i,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  input  logic [31:0]        cpu_wdata_i,
  output logic [31:0]        cpu_rdata_o,
  output logic               cpu_stall_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [31:0]        mem_wdata_o,
  input  logic [31:0]        mem_rdata_i,
  input  logic               mem_ready_i
);
  logic [OFS_W-1:0] ofs, cnt;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag, line_tag;
  logic [1:0]       unused_byte;
  logic vld, dirty, hit, complete, fill_we, inst, word_we, set_dirty;
  logic [31:0] ev_data;
  dmc_state_e state;

  assign unused_byte = cpu_addr_i[1:0];
  assign ofs = cpu_addr_i[2 +: OFS_W];
  assign idx = cpu_addr_i[2+OFS_W +: IDX_W];
  assign tag = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign hit = vld && (line_tag == tag);

  // a store lands only when the access completes against a matching line
  assign word_we   = fill_we || (complete && cpu_req_i && cpu_we_i && hit);
  assign set_dirty = WRITE_BACK && complete && cpu_req_i && cpu_we_i && hit;

  dmc_ctrl #(.LINE_WORDS(LINE_WORDS), .WRITE_BACK(WRITE_BACK)) i_ctrl (
    .clk_i, .rst_ni,
    .req_i(cpu_req_i), .we_i(cpu_we_i), .hit_i(hit), .vld_i(vld), .dirty_i(dirty),
    .mem_ready_i,
    .state_o(state), .cnt_o(cnt), .complete_o(complete), .stall_o(cpu_stall_o),
    .fill_we_o(fill_we), .inst_o(inst), .mem_req_o, .mem_we_o
  );

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
    .clk_i, .rst_ni, .idx_i(idx),
    .vld_o(vld), .dirty_o(dirty), .tag_o(line_tag),
    .inst_i(inst), .inst_tag_i(tag), .set_dirty_i(set_dirty)
  );

  dmc_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS)) i_data (
    .clk_i, .idx_i(idx),
    .rd_ofs_i(ofs), .rd_data_o(cpu_rdata_o),
    .ev_ofs_i(cnt), .ev_data_o(ev_data),
    .we_i(word_we), .wr_ofs_i(fill_we ? cnt : ofs),
    .wr_data_i(fill_we ? mem_rdata_i : cpu_wdata_i)
  );

  always_comb begin
    unique case (state)
      ST_EVICT: mem_addr_o = {line_tag, idx, cnt};
      ST_FILL:  mem_addr_o = {tag, idx, cnt};
      default:  mem_addr_o = cpu_addr_i[ADDR_W-1:2];
    endcase
    mem_wdata_o = (state == ST_EVICT) ? ev_data : cpu_wdata_i;
  end
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter bit WRITE_BACK = 1'b1,
  localparam int OFS_W   = $clog2(LINE_WORDS),
  localparam int MADDR_W = ADDR_W - 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cpu_req_i,
  input logic               cpu_we_i,
  input logic               cpu_stall_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [MADDR_W-1:0] mem_addr_o,
  input logic               mem_ready_i
);
  localparam logic [OFS_W-1:0] LAST = OFS_W'(LINE_WORDS - 1);

  // R5
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R3
  fill_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ready_i && (mem_addr_o[OFS_W-1:0] != LAST)
    |=> mem_req_o && !mem_we_o && (mem_addr_o == MADDR_W'($past(mem_addr_o) + 1'b1)));

  // R4
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ready_i && (mem_addr_o[OFS_W-1:0] == LAST) && cpu_req_i
    |=> !cpu_stall_o);

  // R2
  hit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !cpu_we_i && !cpu_stall_o |-> !mem_req_o);

  generate
    if (WRITE_BACK) begin : g_wb
      // R11
      evict_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o && mem_we_o && mem_ready_i |=> mem_req_o);
    end else begin : g_wt
      // R8
      wt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o && mem_we_o && mem_ready_i |=> !mem_req_o && !cpu_stall_o);
    end
  endgenerate
endmodule

bind dm_cache dm_cache_chk #(
  .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .WRITE_BACK(WRITE_BACK)
) i_dm_cache_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i),
  .cpu_stall_o(cpu_stall_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_ready_i(mem_ready_i)
);

// File: tb/test_mem.sv
module test_mem #(
  parameter int AW  = 6,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          ready,
  output int            wr_cnt
);
  logic [31:0] mem [2**AW];
  int wcnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2**AW; i++) mem[i] <= 32'h5A00_0000 ^ (32'(i) * 32'h0001_0103);
      ready  <= 1'b0;
      wcnt   <= 0;
      wr_cnt <= 0;
      rdata  <= '0;
    end else if (ready) begin
      ready <= 1'b0;
      if (req && we) begin
        mem[addr] <= wdata;
        wr_cnt    <= wr_cnt + 1;
      end
    end else if (req) begin
      if (wcnt == LAT - 1) begin
        ready <= 1'b1;
        wcnt  <= 0;
        if (!we) rdata <= mem[addr];
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end
endmodule

// File: tb/test_dm_cache.sv
`timescale 1ns/1ps
module test_dm_cache;
  localparam int AW    = 8;
  localparam int LW    = 4;
  localparam int NL    = 4;
  localparam int LAT   = 3;
  localparam int WT_   = LAT + 1;
  localparam int MISS  = 1 + LW * WT_;
  localparam int DIRTY = 1 + 2 * LW * WT_;
  localparam int WTS   = 1 + WT_;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req [2], we [2], stall [2], mreq [2], mwe [2], mrdy [2];
  logic [7:0]  addr [2];
  logic [5:0]  maddr [2];
  logic [31:0] wd [2], rd [2], mwd [2], mrd [2];
  int          wrc [2];
  int checks = 0, errors = 0;

  dm_cache #(.ADDR_W(AW), .LINE_WORDS(LW), .LINES(NL), .WRITE_BACK(1'b1)) i_dm_cache (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(req[0]), .cpu_we_i(we[0]), .cpu_addr_i(addr[0]),
    .cpu_wdata_i(wd[0]), .cpu_rdata_o(rd[0]), .cpu_stall_o(stall[0]), .mem_req_o(mreq[0]),
    .mem_we_o(mwe[0]), .mem_addr_o(maddr[0]), .mem_wdata_o(mwd[0]), .mem_rdata_i(mrd[0]),
    .mem_ready_i(mrdy[0]));
  test_mem #(.AW(6), .LAT(LAT)) i_mem_wb (
    .clk(clk), .rst_n(rst_n), .req(mreq[0]), .we(mwe[0]), .addr(maddr[0]), .wdata(mwd[0]),
    .rdata(mrd[0]), .ready(mrdy[0]), .wr_cnt(wrc[0]));

  dm_cache #(.ADDR_W(AW), .LINE_WORDS(LW), .LINES(NL), .WRITE_BACK(1'b0)) i_dm_cache_wt (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(req[1]), .cpu_we_i(we[1]), .cpu_addr_i(addr[1]),
    .cpu_wdata_i(wd[1]), .cpu_rdata_o(rd[1]), .cpu_stall_o(stall[1]), .mem_req_o(mreq[1]),
    .mem_we_o(mwe[1]), .mem_addr_o(maddr[1]), .mem_wdata_o(mwd[1]), .mem_rdata_i(mrd[1]),
    .mem_ready_i(mrdy[1]));
  test_mem #(.AW(6), .LAT(LAT)) i_mem_wt (
    .clk(clk), .rst_n(rst_n), .req(mreq[1]), .we(mwe[1]), .addr(maddr[1]), .wdata(mwd[1]),
    .rdata(mrd[1]), .ready(mrdy[1]), .wr_cnt(wrc[1]));

  function automatic logic [31:0] pat(input int wa);
    return 32'h5A00_0000 ^ (32'(wa) * 32'h0001_0103);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input int u, input bit w, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] r, output int sc);
    @(negedge clk);
    req[u] = 1'b1; we[u] = w; addr[u] = a; wd[u] = d; sc = 0;
    #1;
    while (stall[u] && sc < 1000) begin
      sc++;
      @(negedge clk);
      #1;
    end
    r = rd[u];
    @(posedge clk);
    #1;
    req[u] = 1'b0; we[u] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    for (int u = 0; u < 2; u++) begin
      chk("R6 stall in reset", 32'(stall[u]), 32'd0);
      chk("R6 mem_req in reset", 32'(mreq[u]), 32'd0);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int sc, w0;
    int seq [14] = '{1, 2, 3, 4, 10, 11, 1, 2, 3, 17, 18, 2, 3, 4};
    bit hits [14] = '{0, 1, 1, 0, 0, 1, 1, 1, 1, 0, 1, 0, 1, 1};
    for (int u = 0; u < 2; u++) begin
      req[u] = 0; we[u] = 0; addr[u] = '0; wd[u] = '0;
    end
    do_reset();

    // R7 sequence, with varying byte offsets (R1)
    for (int k = 0; k < 14; k++) begin
      access(0, 1'b0, 8'(seq[k] * 4 + (k % 4)), '0, r, sc);
      chk("R7 stall cycles", 32'(sc), hits[k] ? 32'd0 : 32'(MISS));
      chk("R3 refill data", r, pat(seq[k]));
    end

    // R6: reset drops held lines; full sweep on both variants
    do_reset();
    for (int u = 0; u < 2; u++) begin
      for (int wa = 0; wa < 64; wa++) begin
        access(u, 1'b0, 8'(wa * 4), '0, r, sc);
        if (wa == 1 || wa % 4 != 0) chk("R2 hit no stall", 32'(sc), (wa % 4 != 0) ? 32'd0 : 32'(MISS));
        else chk(wa == 0 ? "R6 first access misses" : "R4 miss stall", 32'(sc), 32'(MISS));
        chk("R2 read data", r, pat(wa));
      end
    end
    for (int b = 1; b < 4; b++) begin
      access(0, 1'b0, 8'(60 * 4 + b), '0, r, sc);
      chk("R1 byte bits ignored stall", 32'(sc), 32'd0);
      chk("R1 byte bits ignored data", r, pat(60));
    end

    // write-back: every line now holds tag 3, clean
    w0 = wrc[0];
    access(0, 1'b1, 8'(5 * 4), 32'hDEAD_0005, r, sc);
    chk("R12 store miss refills", 32'(sc), 32'(MISS));
    chk("R11 clean replace no write", 32'(wrc[0]), 32'(w0));
    chk("R10 memory untouched", i_mem_wb.mem[5], pat(5));
    access(0, 1'b0, 8'(5 * 4), '0, r, sc);
    chk("R12 merged word hits", 32'(sc), 32'd0);
    chk("R12 merged data", r, 32'hDEAD_0005);
    access(0, 1'b1, 8'(6 * 4), 32'hBEEF_0006, r, sc);
    chk("R10 store hit no stall", 32'(sc), 32'd0);
    chk("R10 store hit memory untouched", i_mem_wb.mem[6], pat(6));
    access(0, 1'b0, 8'(21 * 4), '0, r, sc);
    chk("R11 dirty replace stall", 32'(sc), 32'(DIRTY));
    chk("R11 new block data", r, pat(21));
    chk("R11 write count", 32'(wrc[0]), 32'(w0 + LW));
    chk("R11 word0 written back", i_mem_wb.mem[4], pat(4));
    chk("R11 word1 written back", i_mem_wb.mem[5], 32'hDEAD_0005);
    chk("R11 word2 written back", i_mem_wb.mem[6], 32'hBEEF_0006);
    chk("R11 word3 written back", i_mem_wb.mem[7], pat(7));
    access(0, 1'b0, 8'(5 * 4 + 2), '0, r, sc);
    chk("R11 old block misses", 32'(sc), 32'(MISS));
    chk("R11 old block data from memory", r, 32'hDEAD_0005);

    // write-through
    w0 = wrc[1];
    access(1, 1'b1, 8'(9 * 4), 32'hCAFE_0009, r, sc);
    chk("R8 store miss stall", 32'(sc), 32'(WTS));
    chk("R8 single write", 32'(wrc[1]), 32'(w0 + 1));
    chk("R8 memory updated", i_mem_wt.mem[9], 32'hCAFE_0009);
    access(1, 1'b0, 8'(9 * 4), '0, r, sc);
    chk("R8 no allocate on store miss", 32'(sc), 32'(MISS));
    chk("R8 data after refill", r, 32'hCAFE_0009);
    access(1, 1'b1, 8'(10 * 4), 32'hCAFE_000A, r, sc);
    chk("R8 store hit stall", 32'(sc), 32'(WTS));
    chk("R8 store hit memory", i_mem_wt.mem[10], 32'hCAFE_000A);
    access(1, 1'b0, 8'(10 * 4), '0, r, sc);
    chk("R8 store hit cache updated stall", 32'(sc), 32'd0);
    chk("R8 store hit cache updated data", r, 32'hCAFE_000A);
    w0 = wrc[1];
    access(1, 1'b0, 8'(26 * 4), '0, r, sc);
    chk("R9 replace stall", 32'(sc), 32'(MISS));
    chk("R9 replace no write", 32'(wrc[1]), 32'(w0));
    chk("R9 replace data", r, pat(26));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule